// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that gives a host access to a small bank of 8-bit configuration and identity registers belonging to a clock generator. The bus clock and data lines are sampled with the core clock, and the data line is pulled low through an enable output (`sda_oe` high means drive low). The host reaches the bank only through indexed block transfers. A write carries a starting index, a byte count and then that many data bytes. A read first sets the index with a short write phase, then sends a repeated start and the read address. The target answers with the programmed byte-count value and then streams bytes from the index onward. The index advances after every data byte.

The 7-bit target address is picked by a strap input. The strap is captured on the first rising edge of `pwr_good`, together with the 2-bit spread strap code that is read back in register 1. The register fields drive the clock logic directly: eight output enables, eight slew selects, a software spread enable and code, an amplitude code, and the reference-output slew, wake and enable bits.

The controller is a single state machine with these states: ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INDEX, ST_INDEX_ACK, ST_COUNT, ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK and ST_PARK. Its transitions are as follows:
- A start goes from any state to ST_ADDR. A stop goes from any state to ST_IDLE.
- After the address byte, ST_ADDR goes to ST_ADDR_ACK if the address matches, and to ST_PARK if it does not.
- On a write address, ST_ADDR_ACK goes on to ST_INDEX. Then ST_INDEX goes to ST_INDEX_ACK, ST_INDEX_ACK to ST_COUNT, ST_COUNT to ST_COUNT_ACK, and ST_COUNT_ACK to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK while count is left, and ST_WDATA_ACK returns to ST_WDATA. Once the count is used up, ST_WDATA goes to ST_PARK.
- On a read address, ST_ADDR_ACK goes to ST_TX. ST_TX goes to ST_TX_ACK after eight bits. ST_TX_ACK returns to ST_TX when the host acknowledges, and goes to ST_PARK when it does not.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges address 0x68 if `addr_strap` was 0 and 0x6A if it was 1, sampled on the first rising edge of `pwr_good` only. Later strap changes and later `pwr_good` edges have no effect. Before the first `pwr_good` edge no address is acknowledged.
- R2: A non-matching address byte is not acknowledged, and the target keeps SDA released until the next start condition.
- R3: A write of address+W, index N, count X and data bytes stores the bytes into registers N, N+1, … in order. Every byte is acknowledged.
- R4: Data bytes beyond the count X are not acknowledged and not stored.
- R5: After address+W, index N, a repeated start and address+R, the first byte returned is register 7, then registers N, N+1, …. A host NACK ends the read.
- R6: Reset values and field positions are as follows. Register 0 holds the output enables, 0xFF. Register 2 holds the slew selects, 0xFF. Register 1 has the spread enable at bit 5 (reset 0), the spread code at [4:3] (reset 00) and the amplitude at [1:0] (reset 10). Register 3 has the reference slew at [7:6] (reset 01), the wake enable at bit 5 (reset 0) and the reference enable at bit 4 (reset 1). Register 7 holds the read count at [4:0], reset 8.
- R7: Register 5 reads 0x11 and register 6 reads 0x08. Register 1 bits [7:6] read back the latched spread strap code. Writes to these are acknowledged and leave them unchanged.
- R8: Register 4, indices 8 and above, and reserved bits read as 0: register 1 bit 2, register 3 bits [3:0] and register 7 bits [7:5]. Writes to them are acknowledged and ignored.
- R9: A start or stop in the middle of a byte aborts the transfer without changing any register, and the next transaction works normally.
- R10: The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; first rising edge captures the straps |
| addr_strap | input | 1 | Address select strap |
| spread_strap | input | 2 | Decoded spread strap code for readback |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_en | output | 8 | Per-output enable bits |
| slew_fast | output | 8 | Per-output slew select bits |
| ss_sw_en | output | 1 | Software spread control enable |
| ss_sw_code | output | 2 | Software spread code |
| amp_code | output | 2 | Output amplitude code |
| ref_slew | output | 2 | Reference output slew code |
| ref_wake_en | output | 1 | Reference keeps running in power-down |
| ref_out_en | output | 1 | Reference output enable |

## Verification
The bench builds the block with its default parameters. These are the two address choices 0x68 and 0x6A, a two-stage line synchronizer and a read count reset of 8. It drives the strap high, so the low address becomes the non-matching case, and later strap and power-good changes test that the capture happens only once. With only eight real registers, a read that starts at index 4 crosses the reserved, identity and count registers and runs past the end of the bank in five bytes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INDEX, ST_INDEX_ACK,
        ST_COUNT, ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK,
        ST_TX, ST_TX_ACK, ST_PARK
    } smb_state_e;

    typedef struct packed {
        logic [7:0] out_en;
        logic [7:0] slew_fast;
        logic       ss_sw_en;
        logic [1:0] ss_sw_code;
        logic [1:0] amp_code;
        logic [1:0] ref_slew;
        logic       ref_wake_en;
        logic       ref_out_en;
        logic [4:0] rd_count;
    } smb_cfg_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev_q;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = pipe_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  = scl_s & ~prev_q[1];
    assign scl_fall  = ~scl_s & prev_q[1];
    assign start_det = scl_s & prev_q[1] & ~sda_s & prev_q[0];
    assign stop_det  = scl_s & prev_q[1] & sda_s & ~prev_q[0];
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int         IDX_W       = 8,
    parameter logic [7:0] ID_REVISION = 8'h11,
    parameter logic [7:0] ID_DEVICE   = 8'h08,
    parameter logic [4:0] COUNT_RESET = 5'd8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       spread_rb,
    output logic [7:0]       rd_data,
    output smb_cfg_t         cfg
);
    localparam logic [IDX_W-1:0] IX_OUTEN  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_SPREAD = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_SLEW   = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_REF    = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_IDREV  = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_IDDEV  = IDX_W'(6);
    localparam logic [IDX_W-1:0] IX_COUNT  = IDX_W'(7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.out_en      <= 8'hFF;
            cfg.slew_fast   <= 8'hFF;
            cfg.ss_sw_en    <= 1'b0;
            cfg.ss_sw_code  <= 2'b00;
            cfg.amp_code    <= 2'b10;
            cfg.ref_slew    <= 2'b01;
            cfg.ref_wake_en <= 1'b0;
            cfg.ref_out_en  <= 1'b1;
            cfg.rd_count    <= COUNT_RESET;
        end else if (wr_en) begin
            case (wr_idx)
                IX_OUTEN:  cfg.out_en <= wr_data;
                IX_SPREAD: begin
                    cfg.ss_sw_en   <= wr_data[5];
                    cfg.ss_sw_code <= wr_data[4:3];
                    cfg.amp_code   <= wr_data[1:0];
                end
                IX_SLEW:   cfg.slew_fast <= wr_data;
                IX_REF: begin
                    cfg.ref_slew    <= wr_data[7:6];
                    cfg.ref_wake_en <= wr_data[5];
                    cfg.ref_out_en  <= wr_data[4];
                end
                IX_COUNT:  cfg.rd_count <= wr_data[4:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IX_OUTEN:  rd_data = cfg.out_en;
            IX_SPREAD: rd_data = {spread_rb, cfg.ss_sw_en, cfg.ss_sw_code, 1'b0, cfg.amp_code};
            IX_SLEW:   rd_data = cfg.slew_fast;
            IX_REF:    rd_data = {cfg.ref_slew, cfg.ref_wake_en, cfg.ref_out_en, 4'b0000};
            IX_IDREV:  rd_data = ID_REVISION;
            IX_IDDEV:  rd_data = ID_DEVICE;
            IX_COUNT:  rd_data = {3'b000, cfg.rd_count};
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_SEL_LO = 7'h68,
    parameter logic [6:0] ADDR_SEL_HI = 7'h6A,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] COUNT_RESET = 5'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       addr_strap,
    input  logic [1:0] spread_strap,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] out_en,
    output logic [7:0] slew_fast,
    output logic       ss_sw_en,
    output logic [1:0] ss_sw_code,
    output logic [1:0] amp_code,
    output logic [1:0] ref_slew,
    output logic       ref_wake_en,
    output logic       ref_out_en
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // strap capture on the first power-good edge
    logic       pg_prev_q, strap_done_q, addr_hi_q;
    logic [1:0] spread_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_prev_q    <= 1'b0;
            strap_done_q <= 1'b0;
            addr_hi_q    <= 1'b0;
            spread_q     <= 2'b00;
        end else begin
            pg_prev_q <= pwr_good;
            if (pwr_good && !pg_prev_q && !strap_done_q) begin
                strap_done_q <= 1'b1;
                addr_hi_q    <= addr_strap;
                spread_q     <= spread_strap;
            end
        end
    end

    smb_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [BYTE_W-1:0]   sh_q, sh_d, idx_q, idx_d, left_q, left_d;
    logic                rw_q, rw_d, oe_q, oe_d, ackok_q, ackok_d, wr_en;
    logic [BYTE_W-1:0]   rd_data, count_byte;
    logic                byte_full, addr_hit;
    smb_cfg_t            cfg;

    smb_reg_bank #(.IDX_W(BYTE_W), .COUNT_RESET(COUNT_RESET)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx_q), .wr_data(sh_q),
        .rd_idx(idx_q), .spread_rb(spread_q), .rd_data(rd_data), .cfg(cfg)
    );

    assign byte_full  = (cnt_q == CNT_W'(BYTE_W));
    assign addr_hit   = strap_done_q && (sh_q[BYTE_W-1:1] == (addr_hi_q ? ADDR_SEL_HI : ADDR_SEL_LO));
    assign count_byte = {{(BYTE_W-5){1'b0}}, cfg.rd_count};

    always_comb begin
        state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; idx_d = idx_q;
        left_d = left_q; rw_d = rw_q; oe_d = oe_q; ackok_d = ackok_q;
        wr_en = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
        end else if (stop_det) begin
            state_d = ST_IDLE; cnt_d = '0; oe_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_PARK: ;
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && !byte_full) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        cnt_d = '0;
                        oe_d  = 1'b1;
                        unique case (state_q)
                            ST_ADDR: begin
                                if (addr_hit) begin
                                    rw_d = sh_q[0]; state_d = ST_ADDR_ACK;
                                end else begin
                                    oe_d = 1'b0; state_d = ST_PARK;
                                end
                            end
                            ST_INDEX: begin idx_d = sh_q; state_d = ST_INDEX_ACK; end
                            ST_COUNT: begin left_d = sh_q; state_d = ST_COUNT_ACK; end
                            default: begin
                                if (left_q != '0) begin
                                    wr_en   = 1'b1;
                                    idx_d   = idx_q + 1'b1;
                                    left_d  = left_q - 1'b1;
                                    state_d = ST_WDATA_ACK;
                                end else begin
                                    oe_d = 1'b0; state_d = ST_PARK;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    if (rw_q) begin
                        sh_d = count_byte; oe_d = ~count_byte[BYTE_W-1]; state_d = ST_TX;
                    end else begin
                        oe_d = 1'b0; state_d = ST_INDEX;
                    end
                end
                ST_INDEX_ACK: if (scl_fall) begin oe_d = 1'b0; state_d = ST_COUNT; end
                ST_COUNT_ACK, ST_WDATA_ACK: if (scl_fall) begin oe_d = 1'b0; state_d = ST_WDATA; end
                ST_TX: if (scl_fall) begin
                    if (cnt_q == CNT_W'(BYTE_W-1)) begin
                        oe_d = 1'b0; cnt_d = '0; state_d = ST_TX_ACK;
                    end else begin
                        sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                        oe_d  = ~sh_q[BYTE_W-2];
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) ackok_d = ~sda_s;
                    if (scl_fall) begin
                        if (ackok_q) begin
                            sh_d = rd_data; idx_d = idx_q + 1'b1;
                            oe_d = ~rd_data[BYTE_W-1]; state_d = ST_TX;
                        end else begin
                            oe_d = 1'b0; state_d = ST_PARK;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; sh_q <= '0; idx_q <= '0; left_q <= '0;
            rw_q <= 1'b0; oe_q <= 1'b0; ackok_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d; sh_q <= sh_d; idx_q <= idx_d; left_q <= left_d;
            rw_q <= rw_d; oe_q <= oe_d; ackok_q <= ackok_d;
        end
    end

    assign sda_oe      = oe_q;
    assign out_en      = cfg.out_en;
    assign slew_fast   = cfg.slew_fast;
    assign ss_sw_en    = cfg.ss_sw_en;
    assign ss_sw_code  = cfg.ss_sw_code;
    assign amp_code    = cfg.amp_code;
    assign ref_slew    = cfg.ref_slew;
    assign ref_wake_en = cfg.ref_wake_en;
    assign ref_out_en  = cfg.ref_out_en;
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk
    import smb_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input smb_state_e state_q,
    input logic [3:0] cnt_q,
    input logic       strap_done,
    input logic       addr_hi
);
    // R2: parked or idle target never pulls the line
    a_r2_park_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK || state_q == ST_IDLE) |-> !sda_oe);

    // R9: start aborts to address reception with the line released
    a_r9_start_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && !sda_oe && cnt_q == 4'd0));

    // R9: stop returns to idle
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe));

    // R10: data line moves only while the clock line is low
    a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R1: captured address choice never changes once taken
    a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> $stable(addr_hi));

    // R3: bit counter stays within one byte
    a_r3_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 4'd8);
endmodule

bind smb_cfg_target smb_cfg_target_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .state_q(state_q),
    .cnt_q(cnt_q), .strap_done(strap_done_q), .addr_hi(addr_hi_q)
);

// File: tb/smb_cfg_target_tb_top.sv
module smb_cfg_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic addr_strap = 1'b1;
    logic [1:0] spread_strap = 2'b11;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] out_en, slew_fast;
    logic ss_sw_en, ref_wake_en, ref_out_en;
    logic [1:0] ss_sw_code, amp_code, ref_slew;
    int n_tests = 0;
    int n_fail = 0;
    int r10_viol = 0;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    assign sda_bus = ~(host_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_target dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_strap(addr_strap),
        .spread_strap(spread_strap), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .out_en(out_en), .slew_fast(slew_fast), .ss_sw_en(ss_sw_en),
        .ss_sw_code(ss_sw_code), .amp_code(amp_code), .ref_slew(ref_slew),
        .ref_wake_en(ref_wake_en), .ref_out_en(ref_out_en)
    );

    // R10 monitor: sda_oe must only move while SCL is low
    always @(negedge clk) begin
        if (sda_oe !== prev_oe && scl) r10_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; scl = 1'b1; wq();
        host_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        host_low = 1'b0; wq();
        scl = 1'b1; wq();
        host_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        host_low = 1'b1; wq();
        scl = 1'b1; wq();
        host_low = 1'b0; wq();
    endtask

    task automatic put_bit(input logic b);
        host_low = ~b; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        host_low = 1'b0; wq();
        scl = 1'b1; wq();
        acked = (sda_bus == 1'b0);
        wq();
        scl = 1'b0; wq();
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_low = 1'b0; wq();
            scl = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            scl = 1'b0; wq();
        end
        put_bit(~host_ack);
    endtask

    task automatic t_reset();
        chk("R6 out_en reset", out_en, 8'hFF);
        chk("R6 slew reset", slew_fast, 8'hFF);
        chk("R6 spread en reset", ss_sw_en, 0);
        chk("R6 spread code reset", ss_sw_code, 0);
        chk("R6 amp reset", amp_code, 2);
        chk("R6 ref slew reset", ref_slew, 1);
        chk("R6 wake reset", ref_wake_en, 0);
        chk("R6 ref enable reset", ref_out_en, 1);
        chk("R2 idle line released", sda_oe, 0);
    endtask

    task automatic t_before_pg();
        logic a;
        bus_start(); send_byte(8'hD4, a); bus_stop();
        chk("R1 no ack before power-good", a, 0);
    endtask

    task automatic t_power_good();
        pwr_good = 1'b1; repeat (4) @(negedge clk);
        addr_strap = 1'b0; spread_strap = 2'b01;
        pwr_good = 1'b0; repeat (4) @(negedge clk);
        pwr_good = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic t_addr_select();
        logic a;
        bus_start(); send_byte(8'hD0, a);
        chk("R1 low address not taken after latch", a, 0);
        send_byte(8'h00, a);
        chk("R2 line released after mismatch", a, 0);
        bus_stop();
        bus_start(); send_byte(8'hD4, a); bus_stop();
        chk("R1 high address acknowledged", a, 1);
    endtask

    task automatic t_write_main();
        logic a;
        int acks = 0;
        bus_start();
        send_byte(8'hD4, a); acks += int'(a);
        send_byte(8'h00, a); acks += int'(a);
        send_byte(8'h03, a); acks += int'(a);
        send_byte(8'h5A, a); acks += int'(a);
        send_byte(8'h3C, a); acks += int'(a);
        send_byte(8'hA5, a); acks += int'(a);
        bus_stop();
        chk("R3 all bytes acked", acks, 6);
        chk("R3 reg0 written", out_en, 8'h5A);
        chk("R3 reg1 spread enable bit5", ss_sw_en, 1);
        chk("R3 reg1 spread code [4:3]", ss_sw_code, 3);
        chk("R3 reg1 amp [1:0]", amp_code, 0);
        chk("R3 reg2 written", slew_fast, 8'hA5);
    endtask

    task automatic t_ref_write();
        logic a;
        int acks = 0;
        bus_start();
        send_byte(8'hD4, a); acks += int'(a);
        send_byte(8'h03, a); acks += int'(a);
        send_byte(8'h01, a); acks += int'(a);
        send_byte(8'h60, a); acks += int'(a);
        bus_stop();
        chk("R3 ref write acked", acks, 4);
        chk("R6 ref slew [7:6]", ref_slew, 1);
        chk("R6 wake bit5", ref_wake_en, 1);
        chk("R6 ref enable bit4", ref_out_en, 0);
    endtask

    task automatic t_overrun();
        logic a, a2;
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a); send_byte(8'h01, a);
        send_byte(8'hFF, a);
        send_byte(8'h00, a2);
        bus_stop();
        chk("R4 in-count byte acked", a, 1);
        chk("R4 extra byte not acked", a2, 0);
        chk("R4 reg0 written", out_en, 8'hFF);
        chk("R4 reg1 untouched", ss_sw_en, 1);
        chk("R4 reg1 amp untouched", amp_code, 0);
    endtask

    task automatic t_read_main();
        logic a;
        logic [7:0] b;
        logic [7:0] exp_v [8] = '{8'hFF, 8'hF8, 8'hA5, 8'h60, 8'h00, 8'h11, 8'h08, 8'h08};
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a);
        bus_rstart();
        send_byte(8'hD5, a);
        chk("R5 read address acked", a, 1);
        get_byte(1'b1, b);
        chk("R5 count byte first", b, 8);
        for (int i = 0; i < 8; i++) begin
            get_byte(i != 7, b);
            chk($sformatf("R5 R7 R8 read index %0d", i), b, exp_v[i]);
        end
        bus_stop();
        chk("R5 line released after NACK", sda_oe, 0);
    endtask

    task automatic t_ro_writes();
        logic a;
        logic [7:0] b;
        int acks = 0;
        logic [7:0] exp_v [5] = '{8'h00, 8'h11, 8'h08, 8'h05, 8'h00};
        bus_start();
        send_byte(8'hD4, a); acks += int'(a);
        send_byte(8'h04, a); acks += int'(a);
        send_byte(8'h04, a); acks += int'(a);
        send_byte(8'hFF, a); acks += int'(a);
        send_byte(8'h00, a); acks += int'(a);
        send_byte(8'hFF, a); acks += int'(a);
        send_byte(8'hE5, a); acks += int'(a);
        bus_stop();
        chk("R7 R8 writes to read-only acked", acks, 7);
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h04, a);
        bus_rstart();
        send_byte(8'hD5, a);
        get_byte(1'b1, b);
        chk("R8 count keeps [4:0] only", b, 5);
        for (int i = 0; i < 5; i++) begin
            get_byte(i != 4, b);
            chk($sformatf("R7 R8 read index %0d", i + 4), b, exp_v[i]);
        end
        bus_stop();
    endtask

    task automatic t_abort_start();
        logic a;
        bus_start(); send_byte(8'hD4, a); send_byte(8'h00, a);
        put_bit(1); put_bit(0); put_bit(1); put_bit(0);
        bus_rstart();
        send_byte(8'hD4, a);
        chk("R9 ack after start abort", a, 1);
        send_byte(8'h00, a); send_byte(8'h01, a); send_byte(8'h0F, a);
        bus_stop();
        chk("R9 write after start abort", out_en, 8'h0F);
    endtask

    task automatic t_abort_stop();
        logic a;
        bus_start(); send_byte(8'hD4, a); send_byte(8'h02, a); send_byte(8'h01, a);
        put_bit(0); put_bit(0); put_bit(1); put_bit(1);
        bus_stop();
        chk("R9 stop abort leaves reg2", slew_fast, 8'hA5);
        chk("R9 line released after stop", sda_oe, 0);
        bus_start(); send_byte(8'hD4, a); bus_stop();
        chk("R9 next transaction acked", a, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_before_pg();
        t_power_good();
        t_addr_select();
        t_write_main();
        t_ref_write();
        t_overrun();
        t_read_main();
        t_ro_writes();
        t_abort_start();
        t_abort_stop();
        chk("R10 sda_oe moved while SCL high", r10_viol, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule